// File: doc/BRIEF.md
# Masked vector gather load sequencer

This block performs a single masked gather load over a 128-bit or 256-bit vector. A one-cycle start pulse captures five operands: a 64-bit base address, an index vector, a mask vector, the prior destination vector and a small operation code. The sequencer then steps through the elements, lowest first. An element whose mask MSB is set gets one read on a request/response memory port. An element whose mask MSB is clear keeps its old destination value and uses no memory cycle.

The mask is consumed as the block runs. Each mask element becomes zero as soon as its element has been handled, so mid-operation the remaining mask shows exactly what is still to be fetched. At the end, any lanes beyond the used elements are zeroed in both the destination and the mask. A one-cycle done pulse then marks the result as final.

Top module: `gather_seq`

## Requirements
- R1: After reset, `busy`, `done` and `rd_req_valid` are low and `dst_out` and `mask_out` are all zero.
- R2: `op_idx64`=0 selects 32-bit indices in 32-bit lanes and `op_idx64`=1 selects 64-bit indices in 64-bit lanes. `op_dat64`=0 selects 32-bit data lanes and `op_dat64`=1 selects 64-bit data lanes. `op_wide`=1 selects 256-bit length and `op_wide`=0 selects 128-bit length. The element count is 4 (128) or 8 (256) when both widths are 32, and 2 (128) or 4 (256) otherwise. Element i uses index lane i, mask lane i and data lane i.
- R3: Only elements whose mask-lane MSB is set are read. The result data goes into data lane i (the low 32 bits of `rd_rsp_data` for 32-bit data). Other elements keep their prior destination value and issue no request.
- R4: Each request address equals base + (signed index << `op_scale`) modulo 2^64. A 32-bit index is sign-extended first. `rd_size8` is 1 for 8-byte reads and 0 for 4-byte reads.
- R5: Requests go out in ascending element order, with at most one outstanding. A request holds its valid and address until `rd_req_ready`.
- R6: A mask lane becomes zero once its element has been handled, whether or not it was read. `mask_out` is all zero when `done` pulses.
- R7: For 128-bit length, bits 255:128 of the destination are zero on completion.
- R8: With 64-bit indices and 32-bit data, destination bits above the used elements are zero on completion: bits 255:64 at 128-bit length and bits 255:128 at 256-bit length.
- R9: `done` is a one-cycle pulse. A `start` while `busy` is ignored and does not change the operation in flight.
- R10: A `start` in the cycle `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture operands and begin |
| op_idx64 | input | 1 | 1: 64-bit indices |
| op_dat64 | input | 1 | 1: 64-bit data elements |
| op_scale | input | 2 | Index shift amount 0..3 |
| op_wide | input | 1 | 1: 256-bit vector length |
| base_addr | input | 64 | Base address |
| index_vec | input | 256 | Index vector |
| mask_vec | input | 256 | Mask vector |
| dest_vec | input | 256 | Prior destination vector |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_addr | output | 64 | Read address |
| rd_size8 | output | 1 | 1: 8-byte read, 0: 4-byte read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 64 | Read data |
| dst_out | output | 256 | Destination vector |
| mask_out | output | 256 | Mask vector |

## Verification
Two pairs of events can land on the same clock edge. The first pair is the data merge of an element and the clearing of its mask lane. The bench captures `mask_out` at every accepted request and checks two things: the current lane is still set, and every lower lane is already zero. The second pair is completion and a new start. A start is driven in the very cycle `done` is seen high; the bench checks the first result at that moment and then checks that the second operation returns its own result.

// File: rtl/gather_pkg.sv
package gather_pkg;

    parameter int unsigned VEC_W      = 256;
    parameter int unsigned ADDR_W     = 64;
    parameter int unsigned LANE_IDX_W = 3;

    typedef struct packed {
        logic       idx64;
        logic       dat64;
        logic [1:0] scale;
        logic       wide;
    } gth_op_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_REQ  = 2'd2,
        ST_WAIT = 2'd3
    } gth_state_t;

    // number of elements handled for an operation code
    function automatic logic [LANE_IDX_W:0] elem_count(gth_op_t op);
        logic [LANE_IDX_W:0] n;
        n = (op.idx64 || op.dat64) ? (LANE_IDX_W+1)'(2) : (LANE_IDX_W+1)'(4);
        if (op.wide) n = n << 1;
        return n;
    endfunction

    // bits that survive completion; everything above the used lanes is zeroed
    function automatic logic [VEC_W-1:0] keep_bits(gth_op_t op);
        logic [VEC_W-1:0] k;
        k = '1;
        if (!op.wide) k[VEC_W-1:VEC_W/2] = '0;
        if (op.idx64 && !op.dat64) begin
            if (op.wide) k[VEC_W-1:VEC_W/2] = '0;
            else         k[VEC_W-1:VEC_W/4] = '0;
        end
        return k;
    endfunction

endpackage

// File: rtl/gth_addr_gen.sv
module gth_addr_gen
    import gather_pkg::*;
#(
    parameter int unsigned VW = VEC_W,
    parameter int unsigned EW = LANE_IDX_W
)(
    input  gth_op_t           op,
    input  logic [VW-1:0]     idx_vec,
    input  logic [63:0]       base,
    input  logic [EW-1:0]     elem,
    output logic [63:0]       addr
);
    logic [31:0] idx_narrow;
    logic [63:0] idx_full;
    logic [63:0] idx_signed;

    always_comb begin
        idx_narrow = idx_vec[elem*32 +: 32];
        idx_full   = idx_vec[elem[EW-2:0]*64 +: 64];
        idx_signed = op.idx64 ? idx_full : {{32{idx_narrow[31]}}, idx_narrow};
        addr       = base + (idx_signed << op.scale);
    end
endmodule

// File: rtl/gth_vec_state.sv
module gth_vec_state
    import gather_pkg::*;
#(
    parameter int unsigned VW = VEC_W,
    parameter int unsigned EW = LANE_IDX_W
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [VW-1:0] dst_in,
    input  logic [VW-1:0] msk_in,
    input  gth_op_t       op,
    input  logic [EW-1:0] elem,
    input  logic          wr_en,
    input  logic [63:0]   wr_data,
    input  logic          retire,
    input  logic          fin,
    output logic [VW-1:0] dst,
    output logic [VW-1:0] msk,
    output logic          active
);
    logic [VW-1:0] dst_q;
    logic [VW-1:0] msk_q;
    logic [VW-1:0] keep;

    assign keep = keep_bits(op);

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_q <= '0;
            msk_q <= '0;
        end else if (load) begin
            dst_q <= dst_in;
            msk_q <= msk_in;
        end else begin
            if (wr_en) begin
                if (op.dat64) dst_q[elem[EW-2:0]*64 +: 64] <= wr_data;
                else          dst_q[elem*32 +: 32]         <= wr_data[31:0];
            end
            if (retire) begin
                if (op.dat64) msk_q[elem[EW-2:0]*64 +: 64] <= '0;
                else          msk_q[elem*32 +: 32]         <= '0;
            end
            if (fin) begin
                dst_q <= dst_q & keep;
                msk_q <= msk_q & keep;
            end
        end
    end

    assign active = op.dat64 ? msk_q[elem[EW-2:0]*64 + 63] : msk_q[elem*32 + 31];
    assign dst    = dst_q;
    assign msk    = msk_q;

    // R6
    msk_fall_only_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> ((msk_q & ~$past(msk_q)) == '0));
endmodule

// File: rtl/gth_ctrl.sv
module gth_ctrl
    import gather_pkg::*;
#(
    parameter int unsigned EW = LANE_IDX_W
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  gth_op_t       op,
    input  logic          active,
    input  logic          req_ready,
    input  logic          rsp_valid,
    output logic          load,
    output logic          busy,
    output logic          done,
    output logic          req_valid,
    output logic          wr_en,
    output logic          retire,
    output logic          fin,
    output logic [EW-1:0] elem
);
    gth_state_t    state_q;
    logic [EW:0]   elem_q;
    logic [EW:0]   cnt;
    logic          done_q;
    logic          at_end;

    assign cnt    = elem_count(op);
    assign at_end = (elem_q == cnt);
    assign load   = start && (state_q == ST_IDLE);

    always_comb begin
        req_valid = (state_q == ST_REQ);
        wr_en     = (state_q == ST_WAIT) && rsp_valid;
        fin       = (state_q == ST_SCAN) && at_end;
        retire    = wr_en || ((state_q == ST_SCAN) && !at_end && !active);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            elem_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_SCAN;
                    elem_q  <= '0;
                end
                ST_SCAN: begin
                    if (at_end) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else if (active) begin
                        state_q <= ST_REQ;
                    end else begin
                        elem_q <= elem_q + 1'b1;
                    end
                end
                ST_REQ: if (req_ready) state_q <= ST_WAIT;
                ST_WAIT: if (rsp_valid) begin
                    state_q <= ST_SCAN;
                    elem_q  <= elem_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;
    assign elem = elem_q[EW-1:0];

    // R2
    elem_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (elem_q <= cnt));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> req_valid);
endmodule

// File: rtl/gather_seq.sv
module gather_seq
    import gather_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             op_idx64,
    input  logic             op_dat64,
    input  logic [1:0]       op_scale,
    input  logic             op_wide,
    input  logic [63:0]      base_addr,
    input  logic [VEC_W-1:0] index_vec,
    input  logic [VEC_W-1:0] mask_vec,
    input  logic [VEC_W-1:0] dest_vec,
    output logic             busy,
    output logic             done,
    output logic             rd_req_valid,
    input  logic             rd_req_ready,
    output logic [63:0]      rd_addr,
    output logic             rd_size8,
    input  logic             rd_rsp_valid,
    input  logic [63:0]      rd_rsp_data,
    output logic [VEC_W-1:0] dst_out,
    output logic [VEC_W-1:0] mask_out
);
    gth_op_t                 op_q;
    logic [63:0]             base_q;
    logic [VEC_W-1:0]        idx_q;
    logic                    load;
    logic                    active;
    logic                    wr_en;
    logic                    retire;
    logic                    fin;
    logic [LANE_IDX_W-1:0]   elem;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= '0;
            base_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            op_q   <= '{idx64: op_idx64, dat64: op_dat64, scale: op_scale, wide: op_wide};
            base_q <= base_addr;
            idx_q  <= index_vec;
        end
    end

    gth_ctrl #(.EW(LANE_IDX_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op        (op_q),
        .active    (active),
        .req_ready (rd_req_ready),
        .rsp_valid (rd_rsp_valid),
        .load      (load),
        .busy      (busy),
        .done      (done),
        .req_valid (rd_req_valid),
        .wr_en     (wr_en),
        .retire    (retire),
        .fin       (fin),
        .elem      (elem)
    );

    gth_addr_gen #(.VW(VEC_W), .EW(LANE_IDX_W)) u_addr (
        .op      (op_q),
        .idx_vec (idx_q),
        .base    (base_q),
        .elem    (elem),
        .addr    (rd_addr)
    );

    gth_vec_state #(.VW(VEC_W), .EW(LANE_IDX_W)) u_state (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .dst_in  (dest_vec),
        .msk_in  (mask_vec),
        .op      (op_q),
        .elem    (elem),
        .wr_en   (wr_en),
        .wr_data (rd_rsp_data),
        .retire  (retire),
        .fin     (fin),
        .dst     (dst_out),
        .msk     (mask_out),
        .active  (active)
    );

    assign rd_size8 = op_q.dat64;

    // R6
    mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (mask_out == '0));
    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req_valid && !rd_req_ready) |=> $stable(rd_addr));
    // R3
    req_active_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> active);
    // R9
    start_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(base_q) && $stable(idx_q)));
endmodule

// File: tb/test_gather_seq.sv
`timescale 1ns/1ps
module test_gather_seq;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         op_idx64 = 1'b0, op_dat64 = 1'b0, op_wide = 1'b0;
    logic [1:0]   op_scale = 2'd0;
    logic [63:0]  base_addr = '0;
    logic [255:0] index_vec = '0, mask_vec = '0, dest_vec = '0;
    logic         busy, done, rd_req_valid, rd_size8;
    logic         rd_req_ready = 1'b0, rd_rsp_valid = 1'b0;
    logic [63:0]  rd_addr, rd_rsp_data = '0;
    logic [255:0] dst_out, mask_out;

    int checks = 0, fails = 0, cyc = 0;

    // expected results
    logic [255:0] exp_dst;
    logic [63:0]  exp_addr [0:7];
    logic [2:0]   exp_elem [0:7];
    int           exp_n;
    int           exp_lw;
    logic         exp_sz;

    // observed requests
    logic [63:0]  got_addr [0:7];
    logic         got_sz   [0:7];
    logic [255:0] got_msk  [0:7];
    int           nreq = 0;

    gather_seq i_gather_seq (
        .clk(clk), .rst(rst), .start(start),
        .op_idx64(op_idx64), .op_dat64(op_dat64), .op_scale(op_scale), .op_wide(op_wide),
        .base_addr(base_addr), .index_vec(index_vec), .mask_vec(mask_vec), .dest_vec(dest_vec),
        .busy(busy), .done(done),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
        .rd_size8(rd_size8), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .dst_out(dst_out), .mask_out(mask_out)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [63:0] memval(logic [63:0] a);
        return {~a[31:0], a[31:0] ^ 32'hC0DE_1234};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder: variable ready stalls and latency
    initial begin
        bit armed = 0, waiting = 0;
        int lat = 0;
        logic [63:0] cur = '0;
        forever begin
            @(negedge clk);
            rd_rsp_valid = 1'b0;
            if (armed) begin armed = 0; waiting = 1; lat = nreq % 3; end
            if (waiting) begin
                if (lat == 0) begin
                    rd_rsp_valid = 1'b1;
                    rd_rsp_data  = memval(cur);
                    waiting = 0;
                end else lat--;
            end
            rd_req_ready = (cyc % 3) != 1;
            if (rd_req_valid && rd_req_ready) begin
                armed = 1;
                cur = rd_addr;
                if (nreq < 8) begin
                    got_addr[nreq] = rd_addr;
                    got_sz[nreq]   = rd_size8;
                    got_msk[nreq]  = mask_out;
                end
                nreq++;
            end
        end
    end

    task automatic model(input bit i64, input bit d64, input logic [1:0] sc, input bit w,
                         input logic [63:0] b, input logic [255:0] idx,
                         input logic [255:0] msk, input logic [255:0] dst);
        int n;
        n = (!i64 && !d64) ? 4 : 2;
        if (w) n = n * 2;
        exp_lw = d64 ? 64 : 32;
        exp_sz = d64;
        exp_dst = dst;
        exp_n = 0;
        for (int e = 0; e < n; e++) begin
            logic [63:0] ix, a;
            ix = i64 ? idx[e*64 +: 64] : {{32{idx[e*32+31]}}, idx[e*32 +: 32]};
            a  = b + (ix << sc);
            if (msk[e*exp_lw + exp_lw - 1]) begin
                exp_addr[exp_n] = a;
                exp_elem[exp_n] = 3'(e);
                exp_n++;
                for (int k = 0; k < exp_lw; k++) exp_dst[e*exp_lw + k] = memval(a)[k];
            end
        end
        for (int k = n * exp_lw; k < 256; k++) exp_dst[k] = 1'b0;
    endtask

    task automatic launch(input bit i64, input bit d64, input logic [1:0] sc, input bit w,
                          input logic [63:0] b, input logic [255:0] idx,
                          input logic [255:0] msk, input logic [255:0] dst);
        model(i64, d64, sc, w, b, idx, msk, dst);
        op_idx64 = i64; op_dat64 = d64; op_scale = sc; op_wide = w;
        base_addr = b; index_vec = idx; mask_vec = msk; dest_vec = dst;
        nreq = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int t = 0;
        while (!done && t < 500) begin @(negedge clk); t++; end
        chk(done, {tag, " R9 done seen"}, 256'(done), 256'd1);
    endtask

    task automatic check_result(input string tag);
        chk(dst_out == exp_dst, {tag, " R3 R7 R8 dest"}, dst_out, exp_dst);
        chk(mask_out == '0, {tag, " R6 mask cleared"}, mask_out, 256'd0);
        chk(nreq == exp_n, {tag, " R3 request count"}, 256'(nreq), 256'(exp_n));
        for (int k = 0; k < exp_n && k < 8 && k < nreq; k++) begin
            logic [255:0] low;
            chk(got_addr[k] == exp_addr[k], {tag, " R4 R5 address order"}, 256'(got_addr[k]), 256'(exp_addr[k]));
            chk(got_sz[k] == exp_sz, {tag, " R4 size"}, 256'(got_sz[k]), 256'(exp_sz));
            chk(got_msk[k][exp_elem[k]*exp_lw + exp_lw - 1], {tag, " R6 lane still set at request"},
                got_msk[k], 256'd1);
            low = '0;
            for (int j = 0; j < exp_elem[k] * exp_lw; j++) low[j] = got_msk[k][j];
            chk(low == '0, {tag, " R6 lower lanes cleared at request"}, low, 256'd0);
        end
    endtask

    task automatic t_reset();
        chk(!busy && !done && !rd_req_valid, "R1 idle control", {253'd0, busy, done, rd_req_valid}, 256'd0);
        chk(dst_out == '0, "R1 dest zero", dst_out, 256'd0);
        chk(mask_out == '0, "R1 mask zero", mask_out, 256'd0);
    endtask

    task automatic t_dd_wide();
        // 32-bit index, 32-bit data, 256 bits: 8 elements, some negative indices
        launch(0, 0, 2'd2, 1, 64'h0000_0000_1000_0000,
               {32'hFFFF_FFF0, 32'd7, 32'h8000_0000, 32'd3, 32'hFFFF_FFFF, 32'd100, 32'd0, 32'd5},
               {32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h8000_0001, 32'h1, 32'h8000_0000, 32'h8000_0000},
               {8{32'hDEAD_BEEF}});
        wait_done("dd256");
        check_result("dd256 R2");
    endtask

    task automatic t_dq_narrow();
        // 32-bit index, 64-bit data, 128 bits: 2 elements, upper half cleared
        launch(0, 1, 2'd3, 0, 64'h0000_0040_0000_0000,
               {192'h0, 32'hFFFF_FFFE, 32'd9},
               {128'h0, 64'h8000_0000_0000_0000, 64'h0},
               {256{1'b1}});
        wait_done("dq128");
        check_result("dq128 R2 R7");
    endtask

    task automatic t_qd();
        // 64-bit index, 32-bit data: narrowed result
        launch(1, 0, 2'd1, 0, 64'h0000_0000_0000_2000,
               {128'h0, 64'hFFFF_FFFF_FFFF_FF00, 64'd12},
               {{4{32'hFFFF_FFFF}}, 32'h0, 32'h0, 32'h8000_0000, 32'h8000_0000},
               {8{32'h1234_5678}});
        wait_done("qd128");
        check_result("qd128 R8");
        launch(1, 0, 2'd0, 1, 64'h0000_0000_0000_0100,
               {64'd3, 64'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd8},
               {{4{32'hFFFF_FFFF}}, 32'h8000_0000, 32'h0, 32'h8000_0000, 32'h8000_0000},
               {8{32'hA5A5_A5A5}});
        wait_done("qd256");
        check_result("qd256 R8");
    endtask

    task automatic t_qq_wrap();
        // 64-bit index, 64-bit data, scale 1, address wraps modulo 2^64
        launch(1, 1, 2'd1, 1, 64'hFFFF_FFFF_FFFF_FFF0,
               {64'h10, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFC, 64'h20},
               {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF},
               {4{64'h0102_0304_0506_0708}});
        wait_done("qq256");
        check_result("qq256 R4 wrap");
    endtask

    task automatic t_all_off();
        launch(0, 0, 2'd0, 1, 64'h55, {8{32'd1}}, {8{32'h7FFF_FFFF}}, {8{32'hCAFE_F00D}});
        wait_done("none");
        check_result("none R3 no requests");
    endtask

    task automatic t_busy_start();
        logic [255:0] keep_exp;
        launch(0, 0, 2'd0, 0, 64'h800, {128'h0, 32'd4, 32'd3, 32'd2, 32'd1},
               {128'h0, {4{32'h8000_0000}}}, '0);
        keep_exp = exp_dst;
        // ignored start with different operands while busy
        @(negedge clk);
        base_addr = 64'h9999_0000; index_vec = '1; mask_vec = '1; dest_vec = '1; op_dat64 = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("busy");
        chk(dst_out == keep_exp, "R9 start while busy ignored", dst_out, keep_exp);
        check_result("busy R9");
    endtask

    task automatic t_back_to_back();
        launch(0, 1, 2'd0, 1, 64'h1000, {128'h0, 32'd24, 32'd16, 32'd8, 32'd0},
               {64'h8000_0000_0000_0000, 64'h0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000},
               '0);
        wait_done("b2b first");
        check_result("b2b first R10");
        // start in the same cycle done is high
        model(0, 0, 2'd3, 0, 64'h4000, {128'h0, 32'd1, 32'd2, 32'd3, 32'd4},
              {128'h0, 32'h8000_0000, 32'h0, 32'h8000_0000, 32'h0}, {8{32'h7777_7777}});
        op_idx64 = 0; op_dat64 = 0; op_scale = 2'd3; op_wide = 0;
        base_addr = 64'h4000; index_vec = {128'h0, 32'd1, 32'd2, 32'd3, 32'd4};
        mask_vec = {128'h0, 32'h8000_0000, 32'h0, 32'h8000_0000, 32'h0};
        dest_vec = {8{32'h7777_7777}};
        nreq = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R10 start in done cycle accepted", 256'(busy), 256'd1);
        wait_done("b2b second");
        check_result("b2b second R10");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_dd_wide();
        t_dq_narrow();
        t_qd();
        t_qq_wrap();
        t_all_off();
        t_busy_start();
        t_back_to_back();
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule